// File: doc/BRIEF.md
# Exception delegation target resolver

This unit decides which privilege level takes a synchronous exception. It reads the exception cause index, the privilege level the hart runs at, three flags that say whether the supervisor level, the user level and user-level trap handling are implemented, and the two exception-delegation masks: one owned by machine level and one owned by supervisor level. It then names the handling level. A request strobe captures the result in a register. A valid flag rises in the next cycle.

Delegation works in two stages. The machine mask bit for the cause makes the trap a candidate for supervisor handling. A trap can be sent on to user level only when user-level trap handling exists. When the supervisor level exists, that step also needs the supervisor mask bit for the same cause. When the supervisor level is absent, the machine mask bit alone makes the trap a user candidate. The unit never sends a trap to a level below the one the hart is at. In that case the trap stays at the current level.

Control is a two-state machine. `ST_IDLE` (no result pending) moves to `ST_ISSUED` on a request. `ST_ISSUED` (result valid) stays there while requests keep coming and goes back to `ST_IDLE` when the strobe is low. The transitions are named `T_ACCEPT` (IDLE to ISSUED), `T_REPEAT` (ISSUED to ISSUED), `T_RETIRE` (ISSUED to IDLE) and `T_WAIT` (IDLE to IDLE).

Top module: `trap_route_unit`

## Requirements
- R1: After reset, `valid_o` is 0 and `target_o` reads Machine. Levels are encoded as User = 2'b00, Supervisor = 2'b01, Machine = 2'b11.
- R2: `valid_o` is 1 in the cycle after a cycle with `req_i` high, and 0 in the cycle after a cycle with `req_i` low.
- R3: The target is Supervisor in this case: the supervisor level is present, bit `cause_i` of `mdeleg_i` is 1, the trap is not sent on to User, and the current level is not Machine.
- R4: When the supervisor level is present, the target is User only if user level, user trap handling, bit `cause_i` of `mdeleg_i` and bit `cause_i` of `sdeleg_i` are all 1. If `sdeleg_i` is 0 at that bit, the trap stops at Supervisor.
- R5: When the supervisor level is absent, the target is User if user level, user trap handling and bit `cause_i` of `mdeleg_i` are all 1. `sdeleg_i` has no effect on the result.
- R6: When the user level is absent, the target is never User unless the current level is User.
- R7: When bit `cause_i` of `mdeleg_i` is 0, the target is Machine.
- R8: When the chosen level's encoding is below the current level's encoding, the target is the current level.
- R9: A cause index of DELEG_W or above (default 16) resolves to Machine.
- R10: `target_o` holds its value through cycles where `req_i` is low, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Request strobe; captures the resolved level |
| cause_i | input | 6 | Exception cause index |
| cur_lvl_i | input | 2 | Current privilege level |
| has_s_i | input | 1 | Supervisor level implemented |
| has_u_i | input | 1 | User level implemented |
| has_n_i | input | 1 | User-level trap handling implemented |
| mdeleg_i | input | 16 | Machine-owned exception delegation mask |
| sdeleg_i | input | 16 | Supervisor-owned exception delegation mask |
| valid_o | output | 1 | Result valid (the cycle after a request) |
| target_o | output | 2 | Privilege level that handles the trap |

## Verification
The checker assumes that `cur_lvl_i` never carries the reserved code 2'b10. It also assumes the current level is one the configuration can reach, so supervisor is not current while `has_s_i` is 0. The floor and user-exclusion properties rely on these assumptions. The stimulus draws the current level only from User, Supervisor and Machine. It never pairs the supervisor level with an absent supervisor flag, so every vector stays inside those limits. The delegation masks, cause index and flags are otherwise random, and directed vectors cover the out-of-range causes.

// File: rtl/trap_route_pkg.sv
package trap_route_pkg;

    typedef enum logic [1:0] {
        LVL_USER  = 2'b00,
        LVL_SUPER = 2'b01,
        LVL_RSVD  = 2'b10,
        LVL_MACH  = 2'b11
    } lvl_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_ISSUED = 1'b1
    } rstate_e;

endpackage

// File: rtl/trap_mask_pick.sv
module trap_mask_pick #(
    parameter int IDX_W  = 6,
    parameter int MASK_W = 16
) (
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [MASK_W-1:0] mask_i,
    output logic              bit_o
);
    logic [MASK_W-1:0] hit;

    genvar g;
    generate
        for (g = 0; g < MASK_W; g++) begin : g_dec
            assign hit[g] = (idx_i == IDX_W'(g));
        end
    endgenerate

    // An index past the mask matches no row and yields 0.
    assign bit_o = |(hit & mask_i);
endmodule

// File: rtl/trap_level_select.sv
module trap_level_select
    import trap_route_pkg::*;
(
    input  logic has_s_i,
    input  logic has_u_i,
    input  logic has_n_i,
    input  logic mbit_i,
    input  logic sbit_i,
    output lvl_e lvl_o
);
    logic super_cand;
    logic user_cand;

    always_comb begin
        super_cand = mbit_i;
        if (has_s_i) user_cand = super_cand & has_n_i & sbit_i;
        else         user_cand = super_cand & has_n_i;

        if (has_u_i && user_cand)       lvl_o = LVL_USER;
        else if (has_s_i && super_cand) lvl_o = LVL_SUPER;
        else                            lvl_o = LVL_MACH;
    end
endmodule

// File: rtl/trap_level_floor.sv
module trap_level_floor
    import trap_route_pkg::*;
(
    input  lvl_e cand_i,
    input  lvl_e cur_i,
    output lvl_e lvl_o
);
    always_comb begin
        if (cand_i < cur_i) lvl_o = cur_i;
        else                lvl_o = cand_i;
    end
endmodule

// File: rtl/trap_route_unit.sv
module trap_route_unit
    import trap_route_pkg::*;
#(
    parameter int CAUSE_W = 6,
    parameter int DELEG_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_i,
    input  logic [CAUSE_W-1:0] cause_i,
    input  logic [1:0]         cur_lvl_i,
    input  logic               has_s_i,
    input  logic               has_u_i,
    input  logic               has_n_i,
    input  logic [DELEG_W-1:0] mdeleg_i,
    input  logic [DELEG_W-1:0] sdeleg_i,
    output logic               valid_o,
    output logic [1:0]         target_o
);
    rstate_e state_q, state_d;
    lvl_e    target_q;
    logic    mbit, sbit;
    lvl_e    cand_lvl, final_lvl;
    lvl_e    cur_lvl;

    assign cur_lvl = lvl_e'(cur_lvl_i);

    trap_mask_pick #(.IDX_W(CAUSE_W), .MASK_W(DELEG_W)) u_mpick (
        .idx_i (cause_i),
        .mask_i(mdeleg_i),
        .bit_o (mbit)
    );

    trap_mask_pick #(.IDX_W(CAUSE_W), .MASK_W(DELEG_W)) u_spick (
        .idx_i (cause_i),
        .mask_i(sdeleg_i),
        .bit_o (sbit)
    );

    trap_level_select u_sel (
        .has_s_i(has_s_i),
        .has_u_i(has_u_i),
        .has_n_i(has_n_i),
        .mbit_i (mbit),
        .sbit_i (sbit),
        .lvl_o  (cand_lvl)
    );

    trap_level_floor u_floor (
        .cand_i(cand_lvl),
        .cur_i (cur_lvl),
        .lvl_o (final_lvl)
    );

    // Next-state logic: T_ACCEPT, T_REPEAT, T_RETIRE, T_WAIT.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = req_i ? ST_ISSUED : ST_IDLE;
            ST_ISSUED: state_d = req_i ? ST_ISSUED : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output register.
    always_ff @(posedge clk) begin
        if (!rst_n)     target_q <= LVL_MACH;
        else if (req_i) target_q <= final_lvl;
    end

    assign valid_o  = (state_q == ST_ISSUED);
    assign target_o = target_q;
endmodule

// File: rtl/trap_route_chk.sv
module trap_route_chk #(
    parameter int CAUSE_W = 6,
    parameter int DELEG_W = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_i,
    input logic [CAUSE_W-1:0] cause_i,
    input logic [1:0]         cur_lvl_i,
    input logic               has_u_i,
    input logic [DELEG_W-1:0] mdeleg_i,
    input logic               valid_o,
    input logic [1:0]         target_o
);
    // R2
    p_valid_after_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> valid_o);
    // R2
    p_valid_drops_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> !valid_o);
    // R8
    p_no_demote_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> (target_o >= $past(cur_lvl_i)));
    // R9
    p_range_machine_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && (int'(cause_i) >= DELEG_W)) |=> (target_o == 2'b11));
    // R6
    p_no_user_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !has_u_i && (cur_lvl_i != 2'b00)) |=> (target_o != 2'b00));
    // R7
    p_undelegated_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && (int'(cause_i) < DELEG_W) && !mdeleg_i[cause_i[$clog2(DELEG_W)-1:0]])
        |=> (target_o == 2'b11));
    // R10
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> $stable(target_o));
endmodule

bind trap_route_unit trap_route_chk #(.CAUSE_W(CAUSE_W), .DELEG_W(DELEG_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_i    (req_i),
    .cause_i  (cause_i),
    .cur_lvl_i(cur_lvl_i),
    .has_u_i  (has_u_i),
    .mdeleg_i (mdeleg_i),
    .valid_o  (valid_o),
    .target_o (target_o)
);

// File: tb/sim_trap_route_unit.sv
module sim_trap_route_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic [5:0]  cause_i = '0;
    logic [1:0]  cur_lvl_i = 2'b11;
    logic        has_s_i = 1'b0, has_u_i = 1'b0, has_n_i = 1'b0;
    logic [15:0] mdeleg_i = '0, sdeleg_i = '0;
    logic        valid_o;
    logic [1:0]  target_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    trap_route_unit u0 (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .cause_i(cause_i),
        .cur_lvl_i(cur_lvl_i), .has_s_i(has_s_i), .has_u_i(has_u_i),
        .has_n_i(has_n_i), .mdeleg_i(mdeleg_i), .sdeleg_i(sdeleg_i),
        .valid_o(valid_o), .target_o(target_o)
    );

    function automatic logic [1:0] model(input logic [5:0] c, input logic [1:0] cur,
                                         input logic s, input logic u, input logic n,
                                         input logic [15:0] md, input logic [15:0] sd);
        logic mb, sb, sc, uc;
        logic [1:0] t;
        mb = (c < 16) ? md[c[3:0]] : 1'b0;
        sb = (c < 16) ? sd[c[3:0]] : 1'b0;
        sc = mb;
        uc = s ? (sc & n & sb) : (sc & n);
        if (u && uc)      t = 2'b00;
        else if (s && sc) t = 2'b01;
        else              t = 2'b11;
        if (t < cur) t = cur;
        return t;
    endfunction

    task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic fire(input string tag, input logic [5:0] c, input logic [1:0] cur,
                        input logic s, input logic u, input logic n,
                        input logic [15:0] md, input logic [15:0] sd);
        cause_i = c; cur_lvl_i = cur; has_s_i = s; has_u_i = u; has_n_i = n;
        mdeleg_i = md; sdeleg_i = sd; req_i = 1'b1;
        @(negedge clk);
        req_i = 1'b0;
        check({tag, " valid (R2)"}, {1'b0, valid_o}, 2'd1);
        check(tag, target_o, model(c, cur, s, u, n, md, sd));
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'h5eed_0042);
        repeat (3) @(negedge clk);
        check("R1 valid", {1'b0, valid_o}, 2'd0);
        check("R1 target", target_o, 2'b11);
        rst_n = 1'b1;
        @(negedge clk);

        // R3: S present, stops at Supervisor, from User
        fire("R3 super", 6'd2, 2'b00, 1, 1, 1, 16'h0004, 16'h0000);
        check("R3 direct", target_o, 2'b01);
        // R4: both masks set -> User
        fire("R4 user", 6'd8, 2'b00, 1, 1, 1, 16'h0100, 16'h0100);
        check("R4 direct", target_o, 2'b00);
        // R4: no N -> Supervisor
        fire("R4 noN", 6'd8, 2'b00, 1, 1, 0, 16'h0100, 16'h0100);
        check("R4 noN direct", target_o, 2'b01);
        // R5: S absent, sdeleg zero still User
        fire("R5 user", 6'd3, 2'b00, 0, 1, 1, 16'h0008, 16'h0000);
        check("R5 direct", target_o, 2'b00);
        // R6: U absent -> not User
        fire("R6 noU", 6'd3, 2'b01, 1, 0, 1, 16'h0008, 16'h0008);
        check("R6 direct", target_o, 2'b01);
        // R7: machine bit clear
        fire("R7 mach", 6'd5, 2'b00, 1, 1, 1, 16'hFFDF, 16'hFFFF);
        check("R7 direct", target_o, 2'b11);
        // R8: from Machine, delegation ignored
        fire("R8 floor M", 6'd2, 2'b11, 1, 1, 1, 16'hFFFF, 16'hFFFF);
        check("R8 direct M", target_o, 2'b11);
        fire("R8 floor S", 6'd2, 2'b01, 1, 1, 1, 16'hFFFF, 16'hFFFF);
        check("R8 direct S", target_o, 2'b01);
        // R9: out-of-range causes
        fire("R9 idx16", 6'd16, 2'b00, 1, 1, 1, 16'hFFFF, 16'hFFFF);
        check("R9 direct16", target_o, 2'b11);
        fire("R9 idx63", 6'd63, 2'b00, 0, 1, 1, 16'hFFFF, 16'hFFFF);
        check("R9 direct63", target_o, 2'b11);
        fire("R9 idx15", 6'd15, 2'b00, 1, 1, 1, 16'h8000, 16'h8000);
        check("R9 edge15", target_o, 2'b00);

        // R10 / R2: inputs change with strobe low
        cause_i = 6'd1; mdeleg_i = 16'h0000; cur_lvl_i = 2'b11;
        @(negedge clk);
        check("R2 drop", {1'b0, valid_o}, 2'd0);
        check("R10 hold", target_o, 2'b00);

        // random mix
        for (int k = 0; k < 400; k++) begin
            logic [1:0] cur;
            logic       s;
            int         pick;
            s    = 1'($urandom);
            pick = int'($urandom % 3);
            cur  = (pick == 0) ? 2'b00 : (pick == 1 && s) ? 2'b01 : 2'b11;
            fire("R3-R9 random", 6'($urandom % 20), cur, s, 1'($urandom), 1'($urandom),
                 16'($urandom), 16'($urandom));
            if (($urandom % 4) == 0) @(negedge clk);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule